// File: doc/BRIEF.md
# Readout Frame Formatter with Payload Scrambler

This block packs four 30-bit readout packets into one fixed 128-bit frame and feeds that frame, sixteen bits at a time, to a downstream serializer. It sends one word per word-clock cycle, so a frame takes eight cycles. Each frame carries a 4-bit header and 4 parity bits in the clear. The 120 payload bits pass through a self-synchronous scrambler with polynomial x^58 + x^39 + 1. The receiver can therefore lock onto frame boundaries and detect bit errors before it descrambles anything.

The producer presents all four packets at once on one flat bus, with a valid flag. The formatter samples them only in the last word cycle of the frame in flight, and it marks that cycle with a ready flag. If no packets are offered at that moment, the formatter sends an idle frame. An idle frame has its own header and a zero body, so the outgoing stream never pauses. On the output side, a first-word flag marks the word that carries the header.

Top module: `frame_formatter`

## Requirements
- R1: The output is a repeating sequence of eight 16-bit words per frame. `word_first` is 1 on the first word of each frame and 0 on the other seven, so it rises exactly once every eight cycles.
- R2: `pkt_ready` is 1 only during the eighth (last) word of a frame. Packets are taken on the clock edge where `pkt_ready` and `pkt_valid` are both 1. `pkt_valid` and `pkt_data` have no effect in any other cycle.
- R3: The frame is sent most significant bit first. Its top 4 bits (bits 15:12 of the first word) hold the header. The header value is 4'hA for a frame that carries accepted packets, whatever their content.
- R4: Bits 11:8 of the first word hold one parity bit per packet, packet 0 at bit 11 down to packet 3 at bit 8. Each bit is the XOR of that packet's 30 bits before scrambling, which makes the total number of ones even.
- R5: The remaining 120 bits (first word bits 7:0, then words two to eight) carry packet 0 through packet 3, each MSB first. Packet 0 occupies `pkt_data[119:90]`. Each payload bit is sent as d XOR s[38] XOR s[57], where s is a 58-bit history of previously sent scrambled bits and s[0] is the most recent. The history advances over payload bits only and carries over from one data frame to the next.
- R6: When no packets are taken, the frame carries header 4'h5 and 124 zero bits (parity and payload). The scrambler history is left unchanged by an idle frame.
- R7: While `rst_n` is 0: `word_out` is 0, `word_first` is 0 and `pkt_ready` is 1. After release, the scrambler history starts from all ones, and the first frame is taken on the first clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_valid | input | 1 | Four packets are offered on `pkt_data` |
| pkt_data | input | 120 | Packets 0..3, packet 0 in bits 119:90 |
| pkt_ready | output | 1 | Last word of the frame; packets are sampled on this edge |
| word_out | output | 16 | Frame word, header word first |
| word_first | output | 1 | Marks the first word of a frame |

## Verification
The bench first offers all-zero packets, so that a scrambler that ignores its history would pass the payload through unchanged. It then offers all-ones packets: 30 set bits give even parity 0, which exposes a parity bit that is inverted or counts the wrong span. Single-bit packets at each end of a packet expose a packet or bit order that is swapped. Idle frames are placed between data frames, so a design that clocks its scrambler over idle frames puts the wrong bits in the next data frame. During every frame the bench also drives junk packets with `pkt_valid` high. A design that samples outside the ready cycle would then send corrupted frames. A reset in mid-frame checks that the word phase and the scrambler history both restart.

// File: rtl/frame_formatter.sv
module frame_formatter #(
  parameter int PKT_W  = 30,
  parameter int NPKT   = 4,
  parameter int WORD_W = 16,
  parameter int HDR_W  = 4,
  parameter logic [HDR_W-1:0] HDR_DATA = 4'hA,
  parameter logic [HDR_W-1:0] HDR_IDLE = 4'h5,
  parameter int SCR_LEN = 58,
  parameter int SCR_TAP = 39,
  parameter logic [SCR_LEN-1:0] SCR_SEED = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pkt_valid,
  input  logic [PKT_W*NPKT-1:0]  pkt_data,
  output logic                   pkt_ready,
  output logic [WORD_W-1:0]      word_out,
  output logic                   word_first
);
  localparam int PAY_W   = PKT_W * NPKT;
  localparam int FRAME_W = HDR_W + NPKT + PAY_W;
  localparam int NWORDS  = FRAME_W / WORD_W;
  localparam int CNT_W   = $clog2(NWORDS);

  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] frame_q;
  logic [SCR_LEN-1:0] scr_q, scr_d;
  logic [PAY_W-1:0]   pay_scr;
  logic [NPKT-1:0]    par;

  assign pkt_ready  = (cnt == CNT_W'(NWORDS - 1));
  assign word_first = (cnt == '0);
  assign word_out   = frame_q[(FRAME_W - 1) - int'(cnt) * WORD_W -: WORD_W];

  always_comb begin
    for (int k = 0; k < NPKT; k++)
      par[NPKT-1-k] = ^pkt_data[PAY_W-1-k*PKT_W -: PKT_W];
  end

  always_comb begin : scramble
    logic [SCR_LEN-1:0] s;
    logic o;
    s = scr_q;
    pay_scr = '0;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      o = pkt_data[i] ^ s[SCR_TAP-1] ^ s[SCR_LEN-1];
      pay_scr[i] = o;
      s = {s[SCR_LEN-2:0], o};
    end
    scr_d = s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= CNT_W'(NWORDS - 1);
      frame_q <= '0;
      scr_q   <= SCR_SEED;
    end else if (pkt_ready) begin
      cnt <= '0;
      if (pkt_valid) begin
        frame_q <= {HDR_DATA, par, pay_scr};
        scr_q   <= scr_d;
      end else begin
        frame_q <= {HDR_IDLE, {(NPKT + PAY_W){1'b0}}};
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

module frame_formatter_sva #(
  parameter int PKT_W  = 30,
  parameter int NPKT   = 4,
  parameter int WORD_W = 16,
  parameter int HDR_W  = 4,
  parameter logic [HDR_W-1:0] HDR_DATA = 4'hA,
  parameter logic [HDR_W-1:0] HDR_IDLE = 4'h5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pkt_valid,
  input logic [PKT_W*NPKT-1:0] pkt_data,
  input logic                  pkt_ready,
  input logic [WORD_W-1:0]     word_out,
  input logic                  word_first
);
  localparam int PAY_W  = PKT_W * NPKT;
  localparam int NWORDS = (HDR_W + NPKT + PAY_W) / WORD_W;

  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (word_first) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 8'hFF) begin
      gap <= gap + 1'b1;
    end
  end

  function automatic logic [NPKT-1:0] pkt_par(input logic [PAY_W-1:0] d);
    logic [NPKT-1:0] r;
    for (int k = 0; k < NPKT; k++) r[NPKT-1-k] = ^d[PAY_W-1-k*PKT_W -: PKT_W];
    return r;
  endfunction

  p_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_first && seen) |-> gap == 8'(NWORDS - 1));
  p_single_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_first |=> !word_first);
  p_ready_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |=> word_first);
  p_hdr_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && pkt_valid) |=> word_out[WORD_W-1 -: HDR_W] == HDR_DATA);
  p_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && pkt_valid) |=> word_out[WORD_W-1-HDR_W -: NPKT] == pkt_par($past(pkt_data)));
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && !pkt_valid) |=> word_out == {HDR_IDLE, {(WORD_W-HDR_W){1'b0}}});
endmodule

bind frame_formatter frame_formatter_sva #(
  .PKT_W(PKT_W), .NPKT(NPKT), .WORD_W(WORD_W), .HDR_W(HDR_W),
  .HDR_DATA(HDR_DATA), .HDR_IDLE(HDR_IDLE)
) u_sva (.*);

// File: tb/frame_formatter_bench.sv
module frame_formatter_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pkt_valid = 1'b0;
  logic [119:0] pkt_data = '0;
  logic         pkt_ready;
  logic [15:0]  word_out;
  logic         word_first;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [57:0] ms = '1;

  always #2 clk = ~clk;

  frame_formatter u_frame_formatter (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_ready(pkt_ready), .word_out(word_out), .word_first(word_first)
  );

  localparam logic [120:0] VEC [8] = '{
    {1'b1, 30'h00000000, 30'h00000000, 30'h00000000, 30'h00000000},
    {1'b1, 30'h3FFFFFFF, 30'h3FFFFFFF, 30'h3FFFFFFF, 30'h3FFFFFFF},
    {1'b0, 30'h12345678, 30'h3FFFFFFF, 30'h00000001, 30'h20000000},
    {1'b1, 30'h00000001, 30'h20000000, 30'h00008000, 30'h3FFFFFFE},
    {1'b1, 30'h12345678, 30'h0ABCDEF0, 30'h2AAAAAAA, 30'h15555555},
    {1'b0, 30'h00000000, 30'h00000000, 30'h00000000, 30'h00000000},
    {1'b1, 30'h30000001, 30'h0F0F0F0F, 30'h00000003, 30'h2468ACE1},
    {1'b1, 30'h3C3C3C3C, 30'h01010101, 30'h1FFFFFFF, 30'h00000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input logic v, input logic [119:0] pk, output logic [127:0] f);
    logic [57:0] s;
    logic [119:0] p;
    logic [3:0] par;
    logic o;
    if (!v) begin
      f = {4'h5, 124'b0};
    end else begin
      s = ms;
      for (int i = 119; i >= 0; i--) begin
        o = pk[i] ^ s[38] ^ s[57];
        p[i] = o;
        s = {s[56:0], o};
      end
      ms = s;
      for (int k = 0; k < 4; k++) par[3-k] = ^pk[119-30*k -: 30];
      f = {4'hA, par, p};
    end
  endtask

  task automatic send_frame(input logic v, input logic [119:0] pk);
    logic [127:0] f;
    logic [15:0] w;
    model(v, pk, f);
    chk("R2 ready before take", 32'(pkt_ready), 32'd1);
    pkt_valid = v;
    pkt_data  = pk;
    @(posedge clk);
    #1;
    pkt_valid = 1'b1;
    pkt_data  = ~pk ^ 120'h5A5A5A5A5A;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      w = f[127-16*n -: 16];
      if (n == 0) begin
        chk(v ? "R3 header" : "R6 idle header", 32'(word_out[15:12]), 32'(w[15:12]));
        chk(v ? "R4 parity" : "R6 idle parity", 32'(word_out[11:8]), 32'(w[11:8]));
        chk(v ? "R5 payload" : "R6 idle payload", 32'(word_out[7:0]), 32'(w[7:0]));
      end else begin
        chk(v ? "R5 payload" : "R6 idle payload", 32'(word_out), 32'(w));
      end
      chk("R1 first flag", 32'(word_first), 32'(n == 0));
      chk("R2 ready flag", 32'(pkt_ready), 32'(n == 7));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset word", 32'(word_out), 32'd0);
    chk("R7 reset first", 32'(word_first), 32'd0);
    chk("R7 reset ready", 32'(pkt_ready), 32'd1);
    rst_n = 1'b1;

    for (int e = 0; e < 8; e++) send_frame(VEC[e][120], VEC[e][119:0]);

    send_frame(1'b0, '0);
    send_frame(1'b1, {30'h15555555, 30'h2AAAAAAA, 30'h00000000, 30'h3FFFFFFF});

    pkt_valid = 1'b1;
    pkt_data  = {4{30'h0000FFFF}};
    @(posedge clk);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 mid reset word", 32'(word_out), 32'd0);
    chk("R7 mid reset first", 32'(word_first), 32'd0);
    chk("R7 mid reset ready", 32'(pkt_ready), 32'd1);
    rst_n = 1'b1;
    ms = '1;
    send_frame(1'b1, {30'h00000000, 30'h00000000, 30'h00000000, 30'h00000001});
    send_frame(1'b0, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule